// File: doc/BRIEF.md
# MDIO Management Engine with Status Auto-Poll

This block runs IEEE 802.3 clause 22 management transactions on an MDC/MDIO pair towards an external PHY. Two sources share the serial line. The host issues single read or write transactions, and their data passes through one 16-bit data register. A background poller reads one chosen PHY register at a programmable interval and keeps the last good value. It raises a flag when a new reading differs from that value.

Three sticky flags record events: frame completion, a polled status change, and a failed read. The host clears a flag by writing 1 to it. The interrupt output is high while any flag is set together with its enable. MDC comes from the system clock through a programmable divider, and it toggles only while a frame is on the wire.

Top module: `mdio_poll_mgr`

## Requirements
- R1: After reset, mdc is 0, mdio_oe is 0, mdio_o is 1, busy is 0, flags and irq are 0, and mgmt_data and poll_status are 0.
- R2: While a frame runs, each MDC half period lasts mdc_div+1 clock cycles. When no frame runs, mdc stays low.
- R3: A frame is 64 MDC periods long. It sends, MSB first: 32 ones, start code 01, opcode (01 write, 10 read), a 5-bit PHY address, a 5-bit register address, a 2-bit turnaround, then 16 data bits. mdio_o changes only after a falling MDC edge.
- R4: In a write frame mdio_oe stays high for all 64 bits and the turnaround is sent as 10. In a read frame mdio_oe goes low from the first turnaround bit (bit 46) to the end of the frame. mdio_oe is low whenever busy is low.
- R5: In a read frame, mdio_i is sampled at the rising MDC edge of the second turnaround bit. If it is not 0, the read fails: flags[2] is set at frame end, mgmt_data keeps its old value, and a failed poll does not update poll_status.
- R6: An accepted host write loads host_wdata into mgmt_data and sends it. A successful host read loads the 16 data bits sampled on the rising MDC edges into mgmt_data.
- R7: While poll_en is 1, a poll read of poll_phy/poll_reg becomes due poll_gap+1 clock cycles after the previous poll was started or enabled. A successful poll stores the value in poll_status. It sets flags[1] when a stored value already exists and the new value differs from it.
- R8: flags[0] is set at the end of every frame, host or poll, when irq_en[0] is 1. It is not set when irq_en[0] is 0.
- R9: A pending host request starts before a due poll. A poll already running is finished first, and its result is stored.
- R10: Writing 1 to a bit of flag_clr clears that flag. Bits written with 0 leave their flags unchanged. The bit positions are: 0 done, 1 status change, 2 read error.
- R11: irq is 1 exactly when some bit of flags is 1 and the same bit of irq_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc_div | input | DIV_W | MDC half-period minus one, in clock cycles |
| poll_en | input | 1 | Enables the background poller |
| poll_phy | input | 5 | PHY address used by polls |
| poll_reg | input | 5 | Register address used by polls |
| poll_gap | input | GAP_W | Poll interval minus one, in clock cycles |
| host_go | input | 1 | One-cycle host transaction request |
| host_wr | input | 1 | 1 selects write, 0 selects read |
| host_phy | input | 5 | PHY address of the host transaction |
| host_reg | input | 5 | Register address of the host transaction |
| host_wdata | input | 16 | Write data loaded into the data register |
| irq_en | input | 3 | Per-flag interrupt enables |
| flag_clr | input | 3 | Write-1-to-clear strobes for the flags |
| mdio_i | input | 1 | MDIO line as sampled from the pad |
| mgmt_data | output | 16 | Host management data register |
| poll_status | output | 16 | Last successfully polled value |
| flags | output | 3 | Sticky flags: done, change, read error |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | A frame is on the wire |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |

## Verification
A PHY model behind the pins decodes each frame. It keeps a small register file, and a PHY address with no device behind it leaves the line high, so reads of that address fail. A table of host writes and read-backs tells the opcode, the addresses and the data order apart. It also separates a correct turnaround from a failed one, and checks that the data register survives the failure. Polls run first against a steady status value and then against a changed one, which tells a first capture, a repeated equal value and a real change apart. A host request placed in the middle of a poll shows which source wins the line. Changing the divider shows that the MDC rate follows it.

// File: rtl/mdio_poll_mgr.sv
module mdio_poll_mgr #(
  parameter int DIV_W = 8,
  parameter int GAP_W = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] mdc_div,
  input  logic             poll_en,
  input  logic [4:0]       poll_phy,
  input  logic [4:0]       poll_reg,
  input  logic [GAP_W-1:0] poll_gap,
  input  logic             host_go,
  input  logic             host_wr,
  input  logic [4:0]       host_phy,
  input  logic [4:0]       host_reg,
  input  logic [15:0]      host_wdata,
  input  logic [2:0]       irq_en,
  input  logic [2:0]       flag_clr,
  input  logic             mdio_i,
  output logic [15:0]      mgmt_data,
  output logic [15:0]      poll_status,
  output logic [2:0]       flags,
  output logic             irq,
  output logic             busy,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe
);
  localparam int NBITS = 64;
  localparam int CW    = $clog2(NBITS);
  localparam int TA1   = 46;
  localparam int TA2   = 47;
  localparam int DAT0  = 48;

  logic             act, cur_wr, cur_poll, mdc_q, ta_bad, st_valid;
  logic             host_pend, hp_wr, poll_due;
  logic [4:0]       hp_phy, hp_reg;
  logic [GAP_W-1:0] tmr;
  logic [NBITS-1:0] sh;
  logic [CW-1:0]    bitn;
  logic [DIV_W-1:0] dcnt;
  logic [15:0]      rx, data_q, stat_q;
  logic [2:0]       flag_q, set_v;
  logic             tick, rise, fall, last, start_host, start_poll, accept, rd_done, rd_ok;

  function automatic logic [NBITS-1:0] mk_frame(input logic wr, input logic [4:0] pa,
                                                input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, pa, ra, wr ? 2'b10 : 2'b11, wr ? d : 16'hFFFF};
  endfunction

  assign tick       = act && (dcnt == mdc_div);
  assign rise       = tick && !mdc_q;
  assign fall       = tick && mdc_q;
  assign last       = fall && (bitn == CW'(NBITS-1));
  assign start_host = !act && host_pend;
  assign start_poll = !act && !host_pend && poll_due;
  assign accept     = host_go && !host_pend && !(act && !cur_poll);
  assign rd_done    = last && !cur_wr;
  assign rd_ok      = rd_done && !ta_bad;
  assign set_v      = {rd_done && ta_bad,
                       rd_ok && cur_poll && st_valid && (rx != stat_q),
                       last && irq_en[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; cur_wr <= 1'b0; cur_poll <= 1'b0; mdc_q <= 1'b0; ta_bad <= 1'b0;
      sh <= '0; bitn <= '0; dcnt <= '0; rx <= '0;
    end else if (start_host || start_poll) begin
      act      <= 1'b1;
      sh       <= start_host ? mk_frame(hp_wr, hp_phy, hp_reg, data_q)
                             : mk_frame(1'b0, poll_phy, poll_reg, 16'h0);
      cur_wr   <= start_host && hp_wr;
      cur_poll <= start_poll;
      bitn     <= '0;
      dcnt     <= '0;
      mdc_q    <= 1'b0;
      ta_bad   <= 1'b0;
    end else if (act) begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      if (tick) mdc_q <= !mdc_q;
      if (rise && bitn == CW'(TA2)) ta_bad <= mdio_i;
      if (rise && bitn >= CW'(DAT0)) rx <= {rx[14:0], mdio_i};
      if (fall) begin
        sh   <= sh << 1;
        bitn <= bitn + 1'b1;
        if (last) act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_pend <= 1'b0; hp_wr <= 1'b0; hp_phy <= '0; hp_reg <= '0; data_q <= '0;
    end else begin
      if (start_host) host_pend <= 1'b0;
      if (accept) begin
        host_pend <= 1'b1;
        hp_wr     <= host_wr;
        hp_phy    <= host_phy;
        hp_reg    <= host_reg;
        if (host_wr) data_q <= host_wdata;
      end
      if (rd_ok && !cur_poll) data_q <= rx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0; poll_due <= 1'b0; stat_q <= '0; st_valid <= 1'b0;
    end else begin
      if (!poll_en) begin
        tmr      <= '0;
        poll_due <= 1'b0;
      end else if (start_poll) begin
        poll_due <= 1'b0;
      end else if (!poll_due) begin
        if (tmr == poll_gap) begin
          tmr      <= '0;
          poll_due <= 1'b1;
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
      if (rd_ok && cur_poll) begin
        stat_q   <= rx;
        st_valid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~flag_clr) | set_v;
  end

  assign mgmt_data   = data_q;
  assign poll_status = stat_q;
  assign flags       = flag_q;
  assign irq         = |(flag_q & irq_en);
  assign busy        = act;
  assign mdc         = mdc_q;
  assign mdio_o      = act ? sh[NBITS-1] : 1'b1;
  assign mdio_oe     = act && (cur_wr || bitn < CW'(TA1));
endmodule

module mdio_poll_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic [2:0] flags
);
  // R2
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdc);
  // R4
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdio_oe);
  // R3
  mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o));
  // R8
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(flags[0]) |-> $fell(busy));
  // R7
  chg_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(flags[1]) |-> $fell(busy));
  // R5
  err_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(flags[2]) |-> $fell(busy));
endmodule

bind mdio_poll_mgr mdio_poll_mgr_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .flags(flags)
);

// File: tb/mdio_poll_mgr_tb.sv
module mdio_poll_mgr_tb_top;
  localparam int CLK_PER = 10;
  localparam logic [4:0] PHY_ADDR = 5'd1;
  // {wr, phy, reg, wdata, expected mgmt_data, expected read error}
  localparam logic [43:0] VEC [7] = '{
    {1'b1, 5'd1, 5'd3,  16'hA5C3, 16'hA5C3, 1'b0},
    {1'b0, 5'd1, 5'd3,  16'h0000, 16'hA5C3, 1'b0},
    {1'b1, 5'd1, 5'd31, 16'h0001, 16'h0001, 1'b0},
    {1'b0, 5'd1, 5'd31, 16'h0000, 16'h0001, 1'b0},
    {1'b0, 5'd1, 5'd0,  16'h0000, 16'h1100, 1'b0},
    {1'b0, 5'd7, 5'd2,  16'h0000, 16'h1100, 1'b1},
    {1'b0, 5'd1, 5'd9,  16'h0000, 16'h1109, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  mdc_div = 8'd1;
  logic        poll_en = 1'b0;
  logic [4:0]  poll_phy = 5'd1, poll_reg = 5'd1;
  logic [15:0] poll_gap = 16'd30;
  logic        host_go = 1'b0, host_wr = 1'b0;
  logic [4:0]  host_phy = '0, host_reg = '0;
  logic [15:0] host_wdata = '0;
  logic [2:0]  irq_en = 3'b111, flag_clr = 3'b000;
  logic        mdio_i = 1'b1;
  logic [15:0] mgmt_data, poll_status;
  logic [2:0]  flags;
  logic        irq, busy, mdc, mdio_o, mdio_oe;

  int checks = 0, errors = 0;
  logic [15:0] stat_val = 16'h7809;

  always #(CLK_PER/2) clk = ~clk;

  mdio_poll_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .mdc_div(mdc_div), .poll_en(poll_en), .poll_phy(poll_phy),
    .poll_reg(poll_reg), .poll_gap(poll_gap), .host_go(host_go), .host_wr(host_wr),
    .host_phy(host_phy), .host_reg(host_reg), .host_wdata(host_wdata), .irq_en(irq_en),
    .flag_clr(flag_clr), .mdio_i(mdio_i), .mgmt_data(mgmt_data), .poll_status(poll_status),
    .flags(flags), .irq(irq), .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // PHY model
  int          cnt = 0, nfr = 0;
  logic [63:0] seen = '0;
  logic [1:0]  fr_op = '0;
  logic [4:0]  fr_phy = '0, fr_reg = '0, prev_reg = '0;
  logic [15:0] rdval = '0;
  logic        oe_ta = 1'b0;
  logic [15:0] mem [32];
  logic [31:0] wm = '0;

  always @(posedge mdc or negedge mdc) begin
    if (mdc) begin
      if (cnt == 46) oe_ta = mdio_oe;
      seen = {seen[62:0], mdio_o};
      cnt++;
      if (cnt == 46) begin
        fr_op    = seen[11:10];
        fr_phy   = seen[9:5];
        prev_reg = fr_reg;
        fr_reg   = seen[4:0];
        if (fr_reg == 5'd1)  rdval = stat_val;
        else if (wm[fr_reg]) rdval = mem[fr_reg];
        else                 rdval = 16'h1100 + {11'd0, fr_reg};
      end
      if (cnt == 64) begin
        if (seen[29:28] == 2'b01 && seen[27:23] == PHY_ADDR) begin
          mem[seen[22:18]] = seen[15:0];
          wm[seen[22:18]]  = 1'b1;
        end
        cnt = 0;
        nfr++;
      end
    end else begin
      if (fr_op == 2'b10 && fr_phy == PHY_ADDR && cnt == 47) mdio_i <= 1'b0;
      else if (fr_op == 2'b10 && fr_phy == PHY_ADDR && cnt >= 48) mdio_i <= rdval[63-cnt];
      else mdio_i <= 1'b1;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_frame(input int target);
    int n = 0;
    while (nfr < target && n < 20000) begin @(negedge clk); n++; end
    while (busy && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk("watchdog frame wait", 16'd1, 16'd0);
  endtask

  task automatic host_op(input logic w, input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    int tgt;
    tgt = nfr + 1;
    @(negedge clk);
    host_wr = w; host_phy = pa; host_reg = ra; host_wdata = d; host_go = 1'b1;
    @(negedge clk);
    host_go = 1'b0;
    wait_frame(tgt);
  endtask

  task automatic clear_all();
    @(negedge clk); flag_clr = 3'b111;
    @(negedge clk); flag_clr = 3'b000;
  endtask

  logic timed_out = 1'b0;

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mdc", {15'd0, mdc}, 16'd0);
        chk("R1 mdio_oe", {15'd0, mdio_oe}, 16'd0);
        chk("R1 mdio_o", {15'd0, mdio_o}, 16'd1);
        chk("R1 busy", {15'd0, busy}, 16'd0);
        chk("R1 flags/irq", {12'd0, flags, irq}, 16'd0);
        chk("R1 mgmt_data", mgmt_data, 16'd0);
        chk("R1 poll_status", poll_status, 16'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: R3 R4 R5 R6 R8 R11 R10
        for (int i = 0; i < 7; i++) begin
          logic [43:0] v;
          v = VEC[i];
          host_op(v[43], v[42:38], v[37:33], v[32:17]);
          chk("R6 data register", mgmt_data, v[16:1]);
          chk("R5 read error flag", {15'd0, flags[2]}, {15'd0, v[0]});
          chk("R8 done flag", {15'd0, flags[0]}, 16'd1);
          chk("R11 irq", {15'd0, irq}, 16'd1);
          chk("R3 opcode", {14'd0, fr_op}, v[43] ? 16'd1 : 16'd2);
          chk("R3 phy address", {11'd0, fr_phy}, {11'd0, v[42:38]});
          chk("R3 reg address", {11'd0, fr_reg}, {11'd0, v[37:33]});
          chk("R4 turnaround drive", {15'd0, oe_ta}, {15'd0, v[43]});
          clear_all();
          chk("R10 clear all", {13'd0, flags}, 16'd0);
        end

        // R2 divider
        begin
          time t1, t2;
          int tgt;
          mdc_div = 8'd3;
          tgt = nfr + 1;
          @(negedge clk); host_wr = 1'b0; host_phy = 5'd1; host_reg = 5'd4; host_go = 1'b1;
          @(negedge clk); host_go = 1'b0;
          @(posedge mdc); t1 = $time;
          @(posedge mdc); t2 = $time;
          chk("R2 mdc period", 16'(t2 - t1), 16'(2 * 4 * CLK_PER));
          wait_frame(tgt);
          chk("R2 mdc idle low", {15'd0, mdc}, 16'd0);
          chk("R6 read after divider change", mgmt_data, 16'h1104);
          mdc_div = 8'd1;
          clear_all();
        end

        // R8 done suppressed by enable
        irq_en = 3'b110;
        host_op(1'b0, 5'd1, 5'd6, 16'h0);
        chk("R8 no done when disabled", {15'd0, flags[0]}, 16'd0);
        chk("R11 irq low with no flag", {15'd0, irq}, 16'd0);

        // R11 masking
        irq_en = 3'b000;
        host_op(1'b0, 5'd7, 5'd6, 16'h0);
        chk("R5 error flag set", {15'd0, flags[2]}, 16'd1);
        chk("R5 data kept on error", mgmt_data, 16'h1106);
        chk("R11 irq masked", {15'd0, irq}, 16'd0);
        @(negedge clk); irq_en = 3'b100;
        @(negedge clk);
        chk("R11 irq enabled", {15'd0, irq}, 16'd1);

        // R10 partial clear
        irq_en = 3'b101;
        host_op(1'b0, 5'd1, 5'd8, 16'h0);
        chk("R10 before clear", {13'd0, flags}, 16'd5);
        @(negedge clk); flag_clr = 3'b001;
        @(negedge clk); flag_clr = 3'b000;
        chk("R10 partial clear", {13'd0, flags}, 16'd4);
        clear_all();

        // R7 auto-poll
        irq_en = 3'b111;
        poll_gap = 16'd30;
        stat_val = 16'h7809;
        begin
          int tgt;
          tgt = nfr + 1;
          @(negedge clk); poll_en = 1'b1;
          wait_frame(tgt);
          chk("R7 first poll stored", poll_status, 16'h7809);
          chk("R7 first poll no change", {15'd0, flags[1]}, 16'd0);
          chk("R8 poll done flag", {15'd0, flags[0]}, 16'd1);
          chk("R7 poll leaves data register", mgmt_data, 16'h1108);
          clear_all();
          tgt = nfr + 1;
          wait_frame(tgt);
          chk("R7 equal poll no change", {15'd0, flags[1]}, 16'd0);
          stat_val = 16'h782D;
          tgt = nfr + 1;
          wait_frame(tgt);
          chk("R7 change flagged", {15'd0, flags[1]}, 16'd1);
          chk("R7 new status stored", poll_status, 16'h782D);
          clear_all();
        end

        // R9 priority
        begin
          int tgt;
          poll_gap = 16'd0;
          while (!busy) @(negedge clk);
          while (cnt < 10) @(negedge clk);
          stat_val = 16'h7A00;
          tgt = nfr + 2;
          host_wr = 1'b0; host_phy = 5'd1; host_reg = 5'd5; host_go = 1'b1;
          @(negedge clk); host_go = 1'b0;
          wait_frame(tgt);
          chk("R9 poll ran first", {11'd0, prev_reg}, 16'd1);
          chk("R9 host frame next", {11'd0, fr_reg}, 16'd5);
          chk("R9 poll completed", poll_status, 16'h7A00);
          chk("R9 host read data", mgmt_data, 16'h1105);
          @(negedge clk); poll_en = 1'b0;
          while (busy) @(negedge clk);
        end
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) chk("watchdog expired", 16'd1, 16'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule